// File: doc/BRIEF.md
# PHY Test-Port Register Bridge

This block turns two software-visible control words into the serial configuration handshake of a high-speed serial display PHY. One word holds a byte and a flag that marks the byte as an address or as data. The other word holds a strobe bit and a clear bit. Each phase of a configuration write is committed when software takes the strobe from high to low. An address phase selects a PHY register, and a later data phase stores a byte into that register. The test-port pins of the PHY are driven straight from these registered control bits.

Alongside the pins, the bridge keeps a model of the PHY configuration space. This covers the global and PLL registers, five timing registers for the clock lane, and seven timing registers for each data lane. The model has a one-cycle debug read port. It also decodes the three PLL registers into separate field outputs. A system-level bench can use the model to confirm every configuration write without an analog PHY. A sticky flag records any data phase that arrives before an address has been selected.

Top module: `phy_tp_bridge`

## Requirements
- R1: After synchronous reset, test_clk, test_en, test_din, test_clr and seq_err are 0, every configuration register reads its default, and the PLL V register defaults to 0xA0 while all others default to 0x00.
- R2: A host write with host_sel=1 sets test_en to host_wdata bit 16 and test_din to host_wdata bits 7:0 on the next cycle. A host write with host_sel=0 sets test_clk to bit 1 and test_clr to bit 0.
- R3: A strobe falling edge (test_clk 1, then a control write with bit 1 = 0) while test_en is 1 latches test_din as the target address and changes no configuration register.
- R4: A strobe falling edge while test_en is 0 and an address is latched stores test_din into the latched register. The value can be read back through the debug port.
- R5: The latched address persists, so another data phase without a new address phase overwrites the same register.
- R6: A data phase with no address latched since reset or the last clear changes nothing and sets seq_err. seq_err then stays 1 until reset.
- R7: In every cycle in which test_clr is 1, all configuration registers return to defaults and the latched address is dropped. A strobe fall seen while test_clr is 1 commits nothing.
- R8: The register map places the global registers at 0x01 to 0x06 (CFG_I, PLL I to PLL V), the clock lane at 0x10 to 0x14, and data lane n at 0x20+16n to 0x26+16n for n < NUM_LANES. Data writes to any other address are ignored and those addresses read 0.
- R9: PLL I (0x02) decodes as div5f at bit 5, div1f at bit 4, fbd_2p at bits 3:1 and bandwidth-enable at bit 0.
- R10: PLL IV (0x05) decodes as pre_div1p at bit 7 and pre_p at bits 6:0. PLL V (0x06) decodes as vco select at bit 4, lpf_rs at bits 3:2 and lpf_cs at bits 1:0, and pll_v_tag_ok is 1 only when bits 7:5 equal 5.
- R11: Only a 1-to-0 strobe transition commits. A rising strobe, a strobe held high and cycles without a control write commit nothing and leave test_clk and test_clr unchanged.
- R12: dbg_data shows the value held at dbg_addr just before the clock edge that sampled dbg_addr, so a write committed at that same edge appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0: strobe/clear word, 1: address/data word |
| host_wdata | input | HOST_W | Host write data |
| dbg_addr | input | 8 | Debug read address |
| test_clk | output | 1 | PHY test strobe |
| test_en | output | 1 | PHY address/data select |
| test_din | output | 8 | PHY test byte |
| test_clr | output | 1 | PHY configuration clear |
| seq_err | output | 1 | Sticky data-without-address flag |
| dbg_data | output | 8 | Debug read data |
| pll_div5f | output | 1 | PLL I bit 5 |
| pll_div1f | output | 1 | PLL I bit 4 |
| pll_fbd_2p | output | 3 | PLL I bits 3:1 |
| pll_bw_en | output | 1 | PLL I bit 0 |
| pll_pre_div1p | output | 1 | PLL IV bit 7 |
| pll_pre_p | output | 7 | PLL IV bits 6:0 |
| pll_vco_hi | output | 1 | PLL V bit 4 |
| pll_lpf_rs | output | 2 | PLL V bits 3:2 |
| pll_lpf_cs | output | 2 | PLL V bits 1:0 |
| pll_v_tag_ok | output | 1 | PLL V bits 7:5 equal 5 |

## Verification
The handshake is tried with a clean address-then-data pair and with a data phase that has no address before it. It is also tried with repeated data phases on one address, and with a strobe that rises or stays high without falling. Together these separate commit-on-fall from commit-on-level and show that the latched address persists. Writes to every region of the map, including an offset just past a lane's last register, distinguish decoded addresses from ignored ones. A clear that overlaps a strobe fall shows that clear wins. A read issued in the same cycle as the committing edge confirms that the debug port returns the old value.

// File: rtl/phy_tp_pkg.sv
package phy_tp_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_CFG_I    = 8'h01;
  localparam logic [AW-1:0] A_PLL_I    = 8'h02;
  localparam logic [AW-1:0] A_PLL_IV   = 8'h05;
  localparam logic [AW-1:0] A_PLL_V    = 8'h06;
  localparam logic [3:0]    CLK_NIB    = 4'h1;
  localparam logic [3:0]    DAT_NIB0   = 4'h2;
  localparam int            CLK_REGS   = 5;
  localparam int            DAT_REGS   = 7;
  localparam logic [DW-1:0] PLL_V_DFLT = 8'hA0;

  typedef enum logic {PH_IDLE, PH_ARMED} phase_t;

  function automatic logic [DW-1:0] reg_default(input logic [AW-1:0] a);
    return (a == A_PLL_V) ? PLL_V_DFLT : '0;
  endfunction
endpackage

// File: rtl/phy_tp_ctrl.sv
module phy_tp_ctrl
  import phy_tp_pkg::*;
#(
  parameter int HOST_W  = 32,
  parameter int EN_BIT  = 16,
  parameter int STB_BIT = 1,
  parameter int CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              test_clk,
  output logic              test_en,
  output logic [DW-1:0]     test_din,
  output logic              test_clr,
  output logic              cmd_addr,
  output logic              cmd_data
);
  logic strobe_fall;
  logic unused_hi, unused_mid;

  assign unused_hi  = ^host_wdata[HOST_W-1:EN_BIT+1];
  assign unused_mid = ^host_wdata[EN_BIT-1:DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      test_clk <= 1'b0;
      test_clr <= 1'b0;
      test_en  <= 1'b0;
      test_din <= '0;
    end else if (host_wr) begin
      if (host_sel) begin
        test_en  <= host_wdata[EN_BIT];
        test_din <= host_wdata[DW-1:0];
      end else begin
        test_clk <= host_wdata[STB_BIT];
        test_clr <= host_wdata[CLR_BIT];
      end
    end
  end

  // commit only on a 1->0 strobe, never while clear is held
  assign strobe_fall = host_wr && !host_sel && !host_wdata[STB_BIT]
                       && test_clk && !test_clr;
  assign cmd_addr = strobe_fall && test_en;
  assign cmd_data = strobe_fall && !test_en;
endmodule

// File: rtl/phy_tp_seq.sv
module phy_tp_seq
  import phy_tp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          cmd_addr,
  input  logic          cmd_data,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          seq_err
);
  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      wr_addr <= '0;
      seq_err <= 1'b0;
    end else begin
      if (clear) begin
        phase <= PH_IDLE;
      end else if (cmd_addr) begin
        phase   <= PH_ARMED;
        wr_addr <= din[AW-1:0];
      end
      if (cmd_data && phase == PH_IDLE)
        seq_err <= 1'b1;
    end
  end

  assign wr_en = cmd_data && (phase == PH_ARMED);
endmodule

// File: rtl/phy_tp_cfgmem.sv
module phy_tp_cfgmem
  import phy_tp_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]        mem [DEPTH];
  logic [DEPTH-1:0]     written;
  logic [NUM_LANES-1:0] lane_hit;
  logic                 glb_hit, clk_hit, map_hit, wr_ok;
  logic [DW-1:0]        mem_rd;
  logic                 rd_written;
  logic [AW-1:0]        rd_addr_q;

  assign glb_hit = (wr_addr >= A_CFG_I) && (wr_addr <= A_PLL_V);
  assign clk_hit = (wr_addr[7:4] == CLK_NIB) && (int'(wr_addr[3:0]) < CLK_REGS);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic [3:0] NIB = DAT_NIB0 + 4'(g);
    assign lane_hit[g] = (wr_addr[7:4] == NIB) && (int'(wr_addr[3:0]) < DAT_REGS);
  end

  assign map_hit = glb_hit || clk_hit || (|lane_hit);
  assign wr_ok   = wr_en && map_hit;

  // storage without reset so it can map onto block RAM, read-first
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
    mem_rd <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) written <= '0;
    else if (wr_ok)   written[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    rd_addr_q <= rd_addr;
    if (rst) rd_written <= 1'b0;
    else     rd_written <= written[rd_addr];
  end

  assign rd_data = rd_written ? mem_rd : reg_default(rd_addr_q);
endmodule

// File: rtl/phy_tp_pll_dec.sv
module phy_tp_pll_dec
  import phy_tp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          pll_div5f,
  output logic          pll_div1f,
  output logic [2:0]    pll_fbd_2p,
  output logic          pll_bw_en,
  output logic          pll_pre_div1p,
  output logic [6:0]    pll_pre_p,
  output logic          pll_vco_hi,
  output logic [1:0]    pll_lpf_rs,
  output logic [1:0]    pll_lpf_cs,
  output logic          pll_v_tag_ok
);
  logic [DW-1:0] r1, r4, r5;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      r1 <= reg_default(A_PLL_I);
      r4 <= reg_default(A_PLL_IV);
      r5 <= reg_default(A_PLL_V);
    end else if (wr_en) begin
      if (wr_addr == A_PLL_I)  r1 <= wr_data;
      if (wr_addr == A_PLL_IV) r4 <= wr_data;
      if (wr_addr == A_PLL_V)  r5 <= wr_data;
    end
  end

  assign pll_div5f     = r1[5];
  assign pll_div1f     = r1[4];
  assign pll_fbd_2p    = r1[3:1];
  assign pll_bw_en     = r1[0];
  assign pll_pre_div1p = r4[7];
  assign pll_pre_p     = r4[6:0];
  assign pll_v_tag_ok  = (r5[7:5] == 3'd5);
  assign pll_vco_hi    = r5[4];
  assign pll_lpf_rs    = r5[3:2];
  assign pll_lpf_cs    = r5[1:0];
  logic unused_r1;
  assign unused_r1 = ^r1[7:6];
endmodule

// File: rtl/phy_tp_bridge.sv
module phy_tp_bridge
  import phy_tp_pkg::*;
#(
  parameter int HOST_W    = 32,
  parameter int EN_BIT    = 16,
  parameter int STB_BIT   = 1,
  parameter int CLR_BIT   = 0,
  parameter int NUM_LANES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic [7:0]        dbg_addr,
  output logic              test_clk,
  output logic              test_en,
  output logic [7:0]        test_din,
  output logic              test_clr,
  output logic              seq_err,
  output logic [7:0]        dbg_data,
  output logic              pll_div5f,
  output logic              pll_div1f,
  output logic [2:0]        pll_fbd_2p,
  output logic              pll_bw_en,
  output logic              pll_pre_div1p,
  output logic [6:0]        pll_pre_p,
  output logic              pll_vco_hi,
  output logic [1:0]        pll_lpf_rs,
  output logic [1:0]        pll_lpf_cs,
  output logic              pll_v_tag_ok
);
  logic          cmd_addr, cmd_data, wr_en;
  logic [AW-1:0] wr_addr;

  phy_tp_ctrl #(
    .HOST_W(HOST_W), .EN_BIT(EN_BIT), .STB_BIT(STB_BIT), .CLR_BIT(CLR_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .test_clk(test_clk), .test_en(test_en),
    .test_din(test_din), .test_clr(test_clr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  phy_tp_seq u_seq (
    .clk(clk), .rst(rst), .clear(test_clr), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .din(test_din), .wr_en(wr_en),
    .wr_addr(wr_addr), .seq_err(seq_err)
  );

  phy_tp_cfgmem #(.NUM_LANES(NUM_LANES)) u_mem (
    .clk(clk), .rst(rst), .clear(test_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(test_din), .rd_addr(dbg_addr),
    .rd_data(dbg_data)
  );

  phy_tp_pll_dec u_pll (
    .clk(clk), .rst(rst), .clear(test_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(test_din),
    .pll_div5f(pll_div5f), .pll_div1f(pll_div1f), .pll_fbd_2p(pll_fbd_2p),
    .pll_bw_en(pll_bw_en), .pll_pre_div1p(pll_pre_div1p),
    .pll_pre_p(pll_pre_p), .pll_vco_hi(pll_vco_hi),
    .pll_lpf_rs(pll_lpf_rs), .pll_lpf_cs(pll_lpf_cs),
    .pll_v_tag_ok(pll_v_tag_ok)
  );
endmodule

// File: rtl/phy_tp_bridge_chk.sv
module phy_tp_bridge_chk #(
  parameter int HOST_W  = 32,
  parameter int EN_BIT  = 16,
  parameter int STB_BIT = 1,
  parameter int CLR_BIT = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_sel,
  input logic [HOST_W-1:0] host_wdata,
  input logic              test_clk,
  input logic              test_en,
  input logic [7:0]        test_din,
  input logic              test_clr,
  input logic              seq_err,
  input logic              pll_div5f,
  input logic [6:0]        pll_pre_p,
  input logic [2:0]        pll_fbd_2p,
  input logic              pll_v_tag_ok
);
  // R2
  data_word_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sel) |=>
      (test_en == $past(host_wdata[EN_BIT]) && test_din == $past(host_wdata[7:0])));

  // R2
  ctrl_word_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sel) |=>
      (test_clk == $past(host_wdata[STB_BIT]) && test_clr == $past(host_wdata[CLR_BIT])));

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && !host_sel) |=> ($stable(test_clk) && $stable(test_clr)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);

  // R7
  clear_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    test_clr |=> (pll_v_tag_ok && pll_pre_p == 7'd0 && !pll_div5f && pll_fbd_2p == 3'd0));

  // R3
  addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sel && !host_wdata[STB_BIT] && test_clk && test_en && !test_clr)
      |=> ($stable(pll_pre_p) && $stable(pll_fbd_2p) && $stable(pll_div5f)
           && $stable(pll_v_tag_ok)));
endmodule

bind phy_tp_bridge phy_tp_bridge_chk #(
  .HOST_W(HOST_W), .EN_BIT(EN_BIT), .STB_BIT(STB_BIT), .CLR_BIT(CLR_BIT)
) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .test_clk(test_clk), .test_en(test_en),
  .test_din(test_din), .test_clr(test_clr), .seq_err(seq_err),
  .pll_div5f(pll_div5f), .pll_pre_p(pll_pre_p), .pll_fbd_2p(pll_fbd_2p),
  .pll_v_tag_ok(pll_v_tag_ok)
);

// File: tb/phy_tp_bridge_tb.sv
`timescale 1ns/1ps
module phy_tp_bridge_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        host_wr = 0;
  logic        host_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0]  dbg_addr = 0;
  logic        test_clk, test_en, test_clr, seq_err;
  logic [7:0]  test_din, dbg_data;
  logic        pll_div5f, pll_div1f, pll_bw_en, pll_pre_div1p, pll_vco_hi, pll_v_tag_ok;
  logic [2:0]  pll_fbd_2p;
  logic [6:0]  pll_pre_p;
  logic [1:0]  pll_lpf_rs, pll_lpf_cs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  phy_tp_bridge u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .dbg_addr(dbg_addr),
    .test_clk(test_clk), .test_en(test_en), .test_din(test_din),
    .test_clr(test_clr), .seq_err(seq_err), .dbg_data(dbg_data),
    .pll_div5f(pll_div5f), .pll_div1f(pll_div1f), .pll_fbd_2p(pll_fbd_2p),
    .pll_bw_en(pll_bw_en), .pll_pre_div1p(pll_pre_div1p),
    .pll_pre_p(pll_pre_p), .pll_vco_hi(pll_vco_hi),
    .pll_lpf_rs(pll_lpf_rs), .pll_lpf_cs(pll_lpf_cs),
    .pll_v_tag_ok(pll_v_tag_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] cfg [0:255];
  bit         m_clk, m_clr, m_en, m_vld, m_err;
  logic [7:0] m_din, m_addr, e_dbg;

  function automatic logic [7:0] dflt(input int a);
    return (a == 6) ? 8'hA0 : 8'h00;
  endfunction

  function automatic bit mapped(input int a);
    if (a >= 1 && a <= 6) return 1;
    if (a >= 16 && a <= 20) return 1;
    for (int n = 0; n < 4; n++)
      if (a >= 32 + 16*n && a <= 38 + 16*n) return 1;
    return 0;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 256; i++) cfg[i] = dflt(i);
  endtask

  always @(posedge clk) begin
    e_dbg = rst ? dflt(int'(dbg_addr)) : cfg[dbg_addr];
    if (rst) begin
      model_defaults();
      m_clk = 0; m_clr = 0; m_en = 0; m_din = 0; m_vld = 0; m_err = 0; m_addr = 0;
    end else begin
      if (m_clr) begin
        model_defaults();
        m_vld = 0;
      end
      if (host_wr && !host_sel) begin
        if (m_clk && !host_wdata[1] && !m_clr) begin
          if (m_en) begin m_addr = m_din; m_vld = 1; end
          else if (m_vld) begin if (mapped(int'(m_addr))) cfg[m_addr] = m_din; end
          else m_err = 1;
        end
        m_clk = host_wdata[1];
        m_clr = host_wdata[0];
      end else if (host_wr && host_sel) begin
        m_en  = host_wdata[16];
        m_din = host_wdata[7:0];
      end
    end
    #1;
    chk("R2 test_clk", test_clk, m_clk);
    chk("R2 test_clr", test_clr, m_clr);
    chk("R2 test_en", test_en, m_en);
    chk("R2 test_din", test_din, m_din);
    chk("R6 seq_err", seq_err, m_err);
    chk("R12 dbg_data", dbg_data, e_dbg);
    chk("R9 pll I", {pll_div5f, pll_div1f, pll_fbd_2p, pll_bw_en}, cfg[2][5:0]);
    chk("R10 pll IV", {pll_pre_div1p, pll_pre_p}, cfg[5]);
    chk("R10 pll V", {pll_v_tag_ok, pll_vco_hi, pll_lpf_rs, pll_lpf_cs},
        {cfg[6][7:5] == 3'd5, cfg[6][4:0]});
  end

  // ---------------- stimulus helpers ----------------
  task automatic hwr(input bit sel, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic strobe();
    hwr(0, 32'h2);
    hwr(0, 32'h0);
  endtask

  task automatic phy_write(input logic [7:0] a, input logic [7:0] v);
    hwr(1, 32'h0001_0000 | 32'(a));
    strobe();
    hwr(1, 32'(v));
    strobe();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); dbg_addr = a;
    @(negedge clk); v = dbg_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 pins", {test_clk, test_en, test_din, test_clr, seq_err}, 0);
    rd(8'h06, v); chk("R1 PLL V default", v, 8'hA0);
    rd(8'h10, v); chk("R1 clk lane default", v, 8'h00);

    // R6 data phase with no address
    hwr(1, 32'h55); strobe();
    chk("R6 err set", seq_err, 1);
    rd(8'h55, v); chk("R6 no write", v, 8'h00);

    // R3 address phase alone
    hwr(1, 32'h0001_0012); strobe();
    rd(8'h12, v); chk("R3 no change", v, 8'h00);

    // R4 data phase
    hwr(1, 32'h3C); strobe();
    rd(8'h12, v); chk("R4 write", v, 8'h3C);

    // R5 persistent address
    hwr(1, 32'h7E); strobe();
    rd(8'h12, v); chk("R5 rewrite", v, 8'h7E);

    // R11 rising and held strobe do not commit
    hwr(1, 32'h11);
    hwr(0, 32'h2); hwr(0, 32'h2);
    rd(8'h12, v); chk("R11 no commit", v, 8'h7E);
    hwr(0, 32'h0);
    rd(8'h12, v); chk("R11 fall commits", v, 8'h11);

    // R8 map
    phy_write(8'h53, 8'h9A);
    rd(8'h53, v); chk("R8 lane3 trail", v, 8'h9A);
    phy_write(8'h57, 8'h44);
    rd(8'h57, v); chk("R8 lane offset 7 unmapped", v, 8'h00);
    phy_write(8'h15, 8'h44);
    rd(8'h15, v); chk("R8 clk offset 5 unmapped", v, 8'h00);
    phy_write(8'h14, 8'hFF);
    rd(8'h14, v); chk("R8 clk wakeup", v, 8'hFF);

    // R9 PLL I
    phy_write(8'h02, 8'h35);
    chk("R9 fields", {pll_div5f, pll_div1f, pll_fbd_2p, pll_bw_en}, 6'b11_010_1);

    // R10 PLL IV / V
    phy_write(8'h05, 8'h8B);
    chk("R10 IV fields", {pll_pre_div1p, pll_pre_p}, {1'b1, 7'h0B});
    phy_write(8'h06, 8'hB9);
    chk("R10 V fields", {pll_v_tag_ok, pll_vco_hi, pll_lpf_rs, pll_lpf_cs}, 6'b1_1_10_01);
    phy_write(8'h06, 8'h1F);
    chk("R10 V tag bad", {pll_v_tag_ok, pll_vco_hi, pll_lpf_rs, pll_lpf_cs}, 6'b0_1_11_11);

    // R7 clear
    hwr(0, 32'h1); hwr(0, 32'h0);
    rd(8'h12, v); chk("R7 cleared", v, 8'h00);
    rd(8'h06, v); chk("R7 PLL V default", v, 8'hA0);
    chk("R7 pll pre_p", pll_pre_p, 0);
    hwr(1, 32'h0001_0010); strobe();
    hwr(1, 32'h66);
    hwr(0, 32'h3); hwr(0, 32'h0);
    rd(8'h10, v); chk("R7 fall during clear ignored", v, 8'h00);

    // R12 read-first on the committing edge
    @(negedge clk); dbg_addr = 8'h11;
    hwr(1, 32'h0001_0011); strobe();
    hwr(1, 32'h42); hwr(0, 32'h2);
    @(negedge clk); host_wr = 1; host_sel = 0; host_wdata = 32'h0;
    @(posedge clk); #1 chk("R12 old value", dbg_data, 8'h00);
    @(negedge clk); host_wr = 0;
    @(posedge clk); #1 chk("R12 new value", dbg_data, 8'h42);

    // R6 sticky until reset
    chk("R6 still set", seq_err, 1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R6 reset clears", seq_err, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule